// File: doc/BRIEF.md
# Fetch-Group Instruction Extractor

This block sits in a processor front end between the instruction cache and the decode queue. It holds one thread's fetch PC. It asks for the 64-byte line that holds that PC. When the line comes back, it cuts a fetch group out of the line in a single cycle. The group starts at the word the PC points to. Each emitted slot carries the instruction word, its own PC and a sequence number taken from a running counter. The block also reports how many slots in the group are valid.

The group ends at whichever of these comes first:
- the fetch width is reached;
- the last word of the line is emitted;
- a slot is emitted whose word is flagged as a predicted-taken branch;
- a slot is emitted whose word is flagged as a quiesce instruction.

A taken branch redirects the next PC to the target that the predictor supplied for that word. A quiesce instruction parks the thread. If the line comes back with a translation fault, the group is replaced by a single no-op slot that carries the fault code, and the thread parks awaiting the trap. In that case the PC does not move. A resume input (a squash or redirect from later stages) restarts the thread at a new PC from any state. A line response that arrives after such a redirect is dropped.

The thread has four states:
- Run, code 0: the block may request a line.
- Wait, code 1: a request was taken and the line is outstanding.
- Quiesce, code 2: parked after a quiesce instruction.
- Trap, code 3: parked after a fault.

There are five transitions:
- Run to Wait, when a request is accepted.
- Wait to Run, when a clean line returns.
- Wait to Quiesce, when a returned group holds a quiesce word.
- Wait to Trap, when a faulting line returns.
- Any state to Run, on resume.

Top module: `fetch_group_extractor`

## Requirements
- R1: After reset, `thread_state` is 0 (Run), `cur_pc` is RESET_PC, `cur_npc` is RESET_PC+4, `out_count` is 0, and the first slot ever emitted carries sequence number 0.
- R2: In Run, `req_valid` is high and `req_addr` equals `cur_pc` with its low 6 bits cleared. A clock edge with `req_ready` high moves the thread to Wait (code 1).
- R3: While `intr_pending` is high and `phys_mode` is low, `req_valid` is low and the thread stays in Run even with `req_ready` high. With `phys_mode` high, the request is issued.
- R4: The first slot of a group is line word `cur_pc[5:2]`; word w is `line_data[32*w+31:32*w]`. Slot i of a straight-line group carries PC `cur_pc+4*i`. Group outputs appear on the clock edge that samples `line_valid` in Wait.
- R5: A group holds at most FETCH_WIDTH slots. A straight-line group that does not reach the line end holds exactly FETCH_WIDTH slots.
- R6: A group never runs past word 15 of the line. A group starting at word 14 holds two slots and leaves the next PC at the next line's first byte.
- R7: A slot whose word has its `slot_taken` bit set is emitted and ends the group. The next PC becomes that word's target, `slot_target[32*w+31:32*w]`.
- R8: Sequence numbers increase by one per emitted slot, in slot order, and continue across groups. A fault no-op consumes one number.
- R9: A slot whose word has its `slot_quiesce` bit set is emitted and counted, ends the group, and moves the thread to Quiesce (code 2). No request is made in that state.
- R10: After a fault-free group, `cur_pc` becomes the PC after the last slot, and `cur_npc` becomes that value plus 4.
- R11: A line with `line_fault` set emits one slot (`out_count`=1). That slot holds the no-op word NOP_WORD, the current PC, and `out_fault`=1 with `out_fault_code` equal to `fault_code`. The thread moves to Trap (code 3) and `cur_pc` is unchanged.
- R12: `resume_valid` moves the thread to Run from any state, with `cur_pc`=`resume_pc` and `cur_npc`=`resume_pc`+4. A line response arriving while not in Wait emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ready | input | 1 | Cache accepts the line request this cycle |
| intr_pending | input | 1 | An interrupt is pending |
| phys_mode | input | 1 | Fetch address is in physical mode |
| req_valid | output | 1 | Line request valid |
| req_addr | output | ADDR_W | Line-aligned request address |
| line_valid | input | 1 | Line response present |
| line_fault | input | 1 | Response carries a translation fault |
| fault_code | input | FAULT_W | Fault code of the response |
| line_data | input | 512 | Line contents, word w at bits 32w+31:32w |
| slot_taken | input | 16 | Per-word predicted-taken flags |
| slot_quiesce | input | 16 | Per-word quiesce flags |
| slot_target | input | 16*ADDR_W | Per-word predicted targets |
| resume_valid | input | 1 | Redirect the thread |
| resume_pc | input | ADDR_W | Redirect PC |
| out_count | output | CNT_W | Number of valid slots this cycle |
| out_insts | output | FETCH_WIDTH*32 | Slot instruction words |
| out_pcs | output | FETCH_WIDTH*ADDR_W | Slot PCs |
| out_seqs | output | FETCH_WIDTH*SEQ_W | Slot sequence numbers |
| out_fault | output | 1 | Slot 0 is a fault-carrying no-op |
| out_fault_code | output | FAULT_W | Fault code for that slot |
| thread_state | output | 2 | Run 0, Wait 1, Quiesce 2, Trap 3 |
| cur_pc | output | ADDR_W | Thread PC |
| cur_npc | output | ADDR_W | Stored next PC |

## Verification
The bench builds the block with FETCH_WIDTH=4 and RESET_PC=0x1000, keeping the 64-byte line. A width of 4 is well below the 16 words in a line. This lets a group that starts at word 0 hit the width limit. A group that starts at word 14 hits the line end before the width. The two stop causes can therefore be told apart, along with a taken branch and a quiesce that each stop the group mid-width. The default width of 8 would need the same placements. Width 4 keeps the expected slot lists short enough to state exactly.

// File: rtl/fx_pkg.sv
package fx_pkg;

    localparam int INST_W = 32;

    typedef enum logic [1:0] {
        TS_RUN     = 2'd0,
        TS_WAIT    = 2'd1,
        TS_QUIESCE = 2'd2,
        TS_TRAP    = 2'd3
    } thr_state_e;

endpackage

// File: rtl/fx_group_extract.sv
module fx_group_extract
    import fx_pkg::*;
#(
    parameter int FETCH_WIDTH = 8,
    parameter int LINE_WORDS  = 16,
    parameter int ADDR_W      = 32,
    parameter int SEQ_W       = 16,
    parameter int CNT_W       = $clog2(FETCH_WIDTH + 1)
) (
    input  logic [ADDR_W-1:0]             start_pc,
    input  logic [LINE_WORDS*INST_W-1:0]  line_data,
    input  logic [LINE_WORDS-1:0]         taken,
    input  logic [LINE_WORDS-1:0]         quiesce,
    input  logic [LINE_WORDS*ADDR_W-1:0]  targets,
    input  logic [SEQ_W-1:0]              seq_base,
    output logic [FETCH_WIDTH*INST_W-1:0] slot_inst,
    output logic [FETCH_WIDTH*ADDR_W-1:0] slot_pc,
    output logic [FETCH_WIDTH*SEQ_W-1:0]  slot_seq,
    output logic [CNT_W-1:0]              count,
    output logic [ADDR_W-1:0]             end_pc,
    output logic                          hit_quiesce
);

    localparam int WIDX_W = $clog2(LINE_WORDS);

    logic [WIDX_W-1:0] start_word;
    assign start_word = start_pc[WIDX_W+1:2];

    // Walk the slots in order; a stop flag freezes the rest of the group.
    always_comb begin
        logic [ADDR_W-1:0] pc_walk;
        logic              stop;
        logic [WIDX_W:0]   w;
        logic [WIDX_W-1:0] wl;
        pc_walk     = start_pc;
        stop        = 1'b0;
        count       = '0;
        hit_quiesce = 1'b0;
        slot_inst   = '0;
        slot_pc     = '0;
        slot_seq    = '0;
        for (int i = 0; i < FETCH_WIDTH; i++) begin
            w  = {1'b0, start_word} + (WIDX_W+1)'(i);
            wl = w[WIDX_W-1:0];
            if (!stop && !w[WIDX_W]) begin
                slot_inst[i*INST_W +: INST_W] = line_data[wl*INST_W +: INST_W];
                slot_pc[i*ADDR_W +: ADDR_W]   = pc_walk;
                slot_seq[i*SEQ_W +: SEQ_W]    = seq_base + SEQ_W'(i);
                count = count + CNT_W'(1);
                if (taken[wl]) begin
                    pc_walk = targets[wl*ADDR_W +: ADDR_W];
                    stop    = 1'b1;
                end else begin
                    pc_walk = pc_walk + ADDR_W'(4);
                end
                if (quiesce[wl]) begin
                    hit_quiesce = 1'b1;
                    stop        = 1'b1;
                end
            end
        end
        end_pc = pc_walk;
    end

endmodule

// File: rtl/fx_thread_fsm.sv
module fx_thread_fsm
    import fx_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          SEQ_W    = 16,
    parameter int          CNT_W    = 4,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_ready,
    input  logic              intr_pending,
    input  logic              phys_mode,
    input  logic              line_valid,
    input  logic              line_fault,
    input  logic              resume_valid,
    input  logic [ADDR_W-1:0] resume_pc,
    input  logic [CNT_W-1:0]  grp_count,
    input  logic [ADDR_W-1:0] grp_end_pc,
    input  logic              grp_quiesce,
    output logic [1:0]        state_o,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] npc_q,
    output logic [SEQ_W-1:0]  seq_q,
    output logic              req_valid,
    output logic              acc_grp,
    output logic              acc_fault
);

    thr_state_e state_q, state_d;

    // Output and next-state process.
    always_comb begin
        state_d   = state_q;
        req_valid = 1'b0;
        acc_grp   = 1'b0;
        acc_fault = 1'b0;
        unique case (state_q)
            TS_RUN: begin
                req_valid = !(intr_pending && !phys_mode);
                if (req_valid && req_ready) state_d = TS_WAIT;
            end
            TS_WAIT: begin
                if (line_valid && !resume_valid) begin
                    if (line_fault) begin
                        acc_fault = 1'b1;
                        state_d   = TS_TRAP;
                    end else begin
                        acc_grp = 1'b1;
                        state_d = grp_quiesce ? TS_QUIESCE : TS_RUN;
                    end
                end
            end
            TS_QUIESCE: state_d = TS_QUIESCE;
            TS_TRAP:    state_d = TS_TRAP;
            default:    state_d = TS_RUN;
        endcase
        if (resume_valid) state_d = TS_RUN;
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_RUN;
            pc_q    <= ADDR_W'(RESET_PC);
            npc_q   <= ADDR_W'(RESET_PC) + ADDR_W'(4);
            seq_q   <= '0;
        end else begin
            state_q <= state_d;
            if (resume_valid) begin
                pc_q  <= resume_pc;
                npc_q <= resume_pc + ADDR_W'(4);
            end else if (acc_grp) begin
                pc_q  <= grp_end_pc;
                npc_q <= grp_end_pc + ADDR_W'(4);
            end
            if (acc_grp)        seq_q <= seq_q + SEQ_W'(grp_count);
            else if (acc_fault) seq_q <= seq_q + SEQ_W'(1);
        end
    end

    assign state_o = state_q;

    // R8: sequence counter advances by exactly the group size
    p_seq_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_grp) |-> seq_q == $past(seq_q) + SEQ_W'($past(grp_count)));

    // R11: a fault parks the thread and leaves the PC in place
    p_fault_holds_pc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_fault) && !$past(resume_valid) |-> pc_q == $past(pc_q) && state_q == TS_TRAP);

    // R3: an unmasked pending interrupt keeps the thread out of Wait
    p_intr_holds_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == TS_RUN && intr_pending && !phys_mode |=> state_q == TS_RUN);

endmodule

// File: rtl/fetch_group_extractor.sv
module fetch_group_extractor
    import fx_pkg::*;
#(
    parameter int          FETCH_WIDTH = 8,
    parameter int          LINE_BYTES  = 64,
    parameter int          ADDR_W      = 32,
    parameter int          SEQ_W       = 16,
    parameter int          FAULT_W     = 8,
    parameter logic [31:0] RESET_PC    = 32'h0000_1000,
    parameter logic [31:0] NOP_WORD    = 32'h0000_0013,
    localparam int         LINE_WORDS  = LINE_BYTES / 4,
    localparam int         OFF_W       = $clog2(LINE_BYTES),
    localparam int         CNT_W       = $clog2(FETCH_WIDTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_ready,
    input  logic                          intr_pending,
    input  logic                          phys_mode,
    output logic                          req_valid,
    output logic [ADDR_W-1:0]             req_addr,
    input  logic                          line_valid,
    input  logic                          line_fault,
    input  logic [FAULT_W-1:0]            fault_code,
    input  logic [LINE_WORDS*32-1:0]      line_data,
    input  logic [LINE_WORDS-1:0]         slot_taken,
    input  logic [LINE_WORDS-1:0]         slot_quiesce,
    input  logic [LINE_WORDS*ADDR_W-1:0]  slot_target,
    input  logic                          resume_valid,
    input  logic [ADDR_W-1:0]             resume_pc,
    output logic [CNT_W-1:0]              out_count,
    output logic [FETCH_WIDTH*32-1:0]     out_insts,
    output logic [FETCH_WIDTH*ADDR_W-1:0] out_pcs,
    output logic [FETCH_WIDTH*SEQ_W-1:0]  out_seqs,
    output logic                          out_fault,
    output logic [FAULT_W-1:0]            out_fault_code,
    output logic [1:0]                    thread_state,
    output logic [ADDR_W-1:0]             cur_pc,
    output logic [ADDR_W-1:0]             cur_npc
);

    logic [FETCH_WIDTH*INST_W-1:0] x_inst;
    logic [FETCH_WIDTH*ADDR_W-1:0] x_pc;
    logic [FETCH_WIDTH*SEQ_W-1:0]  x_seq;
    logic [CNT_W-1:0]              x_count;
    logic [ADDR_W-1:0]             x_end_pc;
    logic                          x_quiesce;
    logic [SEQ_W-1:0]              seq_q;
    logic                          acc_grp, acc_fault;

    fx_group_extract #(
        .FETCH_WIDTH(FETCH_WIDTH), .LINE_WORDS(LINE_WORDS),
        .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
    ) u_extract (
        .start_pc   (cur_pc),
        .line_data  (line_data),
        .taken      (slot_taken),
        .quiesce    (slot_quiesce),
        .targets    (slot_target),
        .seq_base   (seq_q),
        .slot_inst  (x_inst),
        .slot_pc    (x_pc),
        .slot_seq   (x_seq),
        .count      (x_count),
        .end_pc     (x_end_pc),
        .hit_quiesce(x_quiesce)
    );

    fx_thread_fsm #(
        .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .RESET_PC(RESET_PC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_ready   (req_ready),
        .intr_pending(intr_pending),
        .phys_mode   (phys_mode),
        .line_valid  (line_valid),
        .line_fault  (line_fault),
        .resume_valid(resume_valid),
        .resume_pc   (resume_pc),
        .grp_count   (x_count),
        .grp_end_pc  (x_end_pc),
        .grp_quiesce (x_quiesce),
        .state_o     (thread_state),
        .pc_q        (cur_pc),
        .npc_q       (cur_npc),
        .seq_q       (seq_q),
        .req_valid   (req_valid),
        .acc_grp     (acc_grp),
        .acc_fault   (acc_fault)
    );

    assign req_addr = {cur_pc[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    // Group-level outputs toward the decode queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_count      <= '0;
            out_fault      <= 1'b0;
            out_fault_code <= '0;
        end else begin
            out_count      <= acc_grp ? x_count : (acc_fault ? CNT_W'(1) : '0);
            out_fault      <= acc_fault;
            out_fault_code <= acc_fault ? fault_code : '0;
        end
    end

    // Per-slot registers; slot 0 also carries the fault no-op.
    for (genvar g = 0; g < FETCH_WIDTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_insts[g*32 +: 32]        <= '0;
                out_pcs[g*ADDR_W +: ADDR_W]  <= '0;
                out_seqs[g*SEQ_W +: SEQ_W]   <= '0;
            end else if (acc_fault) begin
                out_insts[g*32 +: 32]        <= (g == 0) ? NOP_WORD : '0;
                out_pcs[g*ADDR_W +: ADDR_W]  <= (g == 0) ? cur_pc : '0;
                out_seqs[g*SEQ_W +: SEQ_W]   <= (g == 0) ? seq_q : '0;
            end else if (acc_grp) begin
                out_insts[g*32 +: 32]        <= x_inst[g*INST_W +: 32];
                out_pcs[g*ADDR_W +: ADDR_W]  <= x_pc[g*ADDR_W +: ADDR_W];
                out_seqs[g*SEQ_W +: SEQ_W]   <= x_seq[g*SEQ_W +: SEQ_W];
            end
        end
    end

    // R5: never more slots than the fetch width
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_count <= CNT_W'(FETCH_WIDTH));

    // R4: an accepted clean line always yields at least one slot
    p_group_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_grp) |-> out_count != '0 && !out_fault);

    // R12: nothing is emitted for a response taken outside Wait
    p_no_emit_outside_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(thread_state) != 2'd1 |-> out_count == '0);

endmodule

// File: tb/tb_fetch_group_extractor.sv
module tb_fetch_group_extractor;

    localparam int FW = 4;
    localparam int AW = 32;
    localparam int SW = 16;
    localparam int CW = $clog2(FW + 1);
    localparam logic [31:0] NOP = 32'h0000_0013;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_ready = 1'b0, intr_pending = 1'b0, phys_mode = 1'b0;
    logic req_valid;
    logic [AW-1:0] req_addr;
    logic line_valid = 1'b0, line_fault = 1'b0;
    logic [7:0] fault_code = '0;
    logic [511:0] line_data;
    logic [15:0] slot_taken = '0, slot_quiesce = '0;
    logic [16*AW-1:0] slot_target = '0;
    logic resume_valid = 1'b0;
    logic [AW-1:0] resume_pc = '0;
    logic [CW-1:0] out_count;
    logic [FW*32-1:0] out_insts;
    logic [FW*AW-1:0] out_pcs;
    logic [FW*SW-1:0] out_seqs;
    logic out_fault;
    logic [7:0] out_fault_code;
    logic [1:0] thread_state;
    logic [AW-1:0] cur_pc, cur_npc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fetch_group_extractor #(
        .FETCH_WIDTH(FW), .RESET_PC(32'h0000_1000), .NOP_WORD(NOP)
    ) dut (.*);

    initial begin
        for (int w = 0; w < 16; w++) line_data[w*32 +: 32] = 32'hC0DE_0000 + w;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue();
        req_ready = 1'b1;
        step();
        req_ready = 1'b0;
    endtask

    task automatic give_line(input logic flt, input logic [7:0] code);
        line_valid = 1'b1; line_fault = flt; fault_code = code;
        step();
        line_valid = 1'b0; line_fault = 1'b0;
    endtask

    task automatic resume(input logic [31:0] pc);
        resume_valid = 1'b1; resume_pc = pc;
        step();
        resume_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 state", 32'(thread_state), 0);
        chk("R1 pc", cur_pc, 32'h1000);
        chk("R1 npc", cur_npc, 32'h1004);
        chk("R1 count", 32'(out_count), 0);
        chk("R2 req_valid", 32'(req_valid), 1);
        chk("R2 req_addr", req_addr, 32'h1000);
    endtask

    task automatic t_width();
        issue();
        chk("R2 wait state", 32'(thread_state), 1);
        give_line(1'b0, 8'h0);
        chk("R5 count", 32'(out_count), 4);
        chk("R4 slot0 inst", out_insts[31:0], 32'hC0DE_0000);
        chk("R4 slot3 pc", out_pcs[3*AW +: AW], 32'h100C);
        chk("R1 first seq", 32'(out_seqs[0 +: SW]), 0);
        chk("R8 slot3 seq", 32'(out_seqs[3*SW +: SW]), 3);
        chk("R10 pc", cur_pc, 32'h1010);
        chk("R10 npc", cur_npc, 32'h1014);
        chk("R10 state run", 32'(thread_state), 0);
    endtask

    task automatic t_line_end();
        resume(32'h1038);
        chk("R2 aligned addr", req_addr, 32'h1000);
        issue();
        give_line(1'b0, 8'h0);
        chk("R6 count", 32'(out_count), 2);
        chk("R4 slot0 inst word14", out_insts[31:0], 32'hC0DE_000E);
        chk("R6 slot1 pc", out_pcs[AW +: AW], 32'h103C);
        chk("R6 next pc", cur_pc, 32'h1040);
        chk("R8 seq continues", 32'(out_seqs[0 +: SW]), 4);
    endtask

    task automatic t_taken();
        slot_taken = 16'h0002;
        for (int w = 0; w < 16; w++) slot_target[w*AW +: AW] = 32'h2000;
        issue();
        give_line(1'b0, 8'h0);
        slot_taken = '0;
        chk("R7 count", 32'(out_count), 2);
        chk("R7 slot1 pc", out_pcs[AW +: AW], 32'h1044);
        chk("R7 target pc", cur_pc, 32'h2000);
        chk("R8 seq", 32'(out_seqs[0 +: SW]), 6);
    endtask

    task automatic t_quiesce();
        slot_quiesce = 16'h0004;
        issue();
        give_line(1'b0, 8'h0);
        slot_quiesce = '0;
        chk("R9 count", 32'(out_count), 3);
        chk("R9 state", 32'(thread_state), 2);
        chk("R9 pc", cur_pc, 32'h200C);
        chk("R8 slot2 seq", 32'(out_seqs[2*SW +: SW]), 10);
        chk("R9 no request", 32'(req_valid), 0);
    endtask

    task automatic t_intr();
        resume(32'h3000);
        chk("R12 resume state", 32'(thread_state), 0);
        chk("R12 resume npc", cur_npc, 32'h3004);
        intr_pending = 1'b1; phys_mode = 1'b0;
        #0;
        chk("R3 held req", 32'(req_valid), 0);
        issue();
        chk("R3 stays run", 32'(thread_state), 0);
        phys_mode = 1'b1;
        #0;
        chk("R3 phys req", 32'(req_valid), 1);
        chk("R3 phys addr", req_addr, 32'h3000);
        intr_pending = 1'b0; phys_mode = 1'b0;
    endtask

    task automatic t_fault();
        issue();
        give_line(1'b1, 8'h5A);
        chk("R11 count", 32'(out_count), 1);
        chk("R11 fault", 32'(out_fault), 1);
        chk("R11 code", 32'(out_fault_code), 32'h5A);
        chk("R11 nop", out_insts[31:0], NOP);
        chk("R11 slot pc", out_pcs[0 +: AW], 32'h3000);
        chk("R8 fault seq", 32'(out_seqs[0 +: SW]), 11);
        chk("R11 state", 32'(thread_state), 3);
        chk("R11 pc held", cur_pc, 32'h3000);
    endtask

    task automatic t_resume_drop();
        resume(32'h4000);
        chk("R12 from trap", 32'(thread_state), 0);
        issue();
        resume(32'h5000);
        chk("R12 from wait", 32'(thread_state), 0);
        chk("R12 new pc", cur_pc, 32'h5000);
        give_line(1'b0, 8'h0);
        chk("R12 dropped count", 32'(out_count), 0);
        chk("R12 pc kept", cur_pc, 32'h5000);
        issue();
        give_line(1'b0, 8'h0);
        chk("R8 after fault seq", 32'(out_seqs[0 +: SW]), 12);
        chk("R4 slot0 pc", out_pcs[0 +: AW], 32'h5000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_width();
        t_line_end();
        t_taken();
        t_quiesce();
        t_intr();
        t_fault();
        t_resume_drop();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule